// File: doc/BRIEF.md
# Polyphase Decimating Filter Bank

This block is the front end of a 64-channel channelizer. A wideband input stream is dealt out, one sample per accepted input, across 64 branches of an 8-tap-per-branch prototype lowpass filter. Every accepted sample produces exactly one filtered branch output. Branch outputs leave in natural order 0..63 with a branch index and a frame-start flag, and feed a streaming 64-point DFT that completes basebanding and decimation for all channels at once.

A single set of 8 multipliers is shared by every branch. The branch index rotates each time a sample is accepted and selects both the coefficient word of every tap and the slot of the commutated delay memory. The 512 coefficients are held in a read-registered memory, eight words wide and one row per branch. The delay memory holds, for each branch slot, the seven older samples of that branch. The eight signed products are summed in a registered binary adder tree. The datapath never stalls: idle input cycles pass through as bubbles.

There is no state machine beyond the rotating branch counter. It has two named transitions: ADVANCE, taken when a sample is accepted, and HOLD, taken on an idle cycle. From branch 63, ADVANCE wraps to branch 0.

Top module: `pp_channelizer`

## Requirements
- R1: After reset, out_valid and out_first are 0, the first accepted sample gets branch 0, and every delay slot reads as zero.
- R2: The n-th accepted sample after reset (counting from 0) is assigned branch p = n mod 64. Its output carries p on out_phase, and the index wraps from 63 to 0.
- R3: out_first is 1 on a valid output exactly when out_phase is 0, and 0 otherwise.
- R4: For the n-th accepted sample x[n], the output is y = sum over k=0..7 of h[64k+p]*x[n-64k]. Samples before the first accepted one count as 0. The products are signed and the sum keeps full precision in 35 bits, two's complement.
- R5: The coefficient at flat index i (0..511) is h[i] = ((37*i + 11) mod 251) - 125. Tap k of branch p uses index 64k+p.
- R6: The output for a sample accepted at clock edge t is presented after edge t+4, a fixed latency of 5 edges. out_valid equals in_valid delayed by those 5 edges.
- R7: A cycle with in_valid low is ignored. in_data is not used, the branch index does not advance, the delay memory is unchanged, and the cycle yields no valid output.
- R8: With in_valid held high, a valid output appears on every clock and branch indices follow each other without gaps.
- R9: Full-scale samples (-32768 and +32767) give exact sums with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Signed wideband input sample |
| out_valid | output | 1 | Output qualifier |
| out_data | output | 35 | Signed branch filter output |
| out_phase | output | 6 | Branch index of the output |
| out_first | output | 1 | High on branch 0 (frame start) |

## Verification
On every cycle, assertions check how the branch counter moves: it wraps after 63 and holds on idle input. They also check that the delay memory stores the accepted sample in its slot, that valid outputs carry consecutive branch indices, and that the frame flag agrees with the branch index. Only the bench's reference model can show the filter arithmetic. That covers coefficient placement, the 64-sample spacing of taps inside a branch, the zero history after reset, the exact 5-edge latency, and the sums at full scale. These are exercised with continuous ramps, gapped random streams and extreme-value blocks.

// File: rtl/pp_chan_pkg.sv
package pp_chan_pkg;
    // Prototype filter coefficient at flat index i (tap-major: i = tap*NPH + phase)
    function automatic int coef_at(int i);
        return ((i * 37 + 11) % 251) - 125;
    endfunction
endpackage

// File: rtl/pp_delay_bank.sv
module pp_delay_bank #(
    parameter int NPH  = 64,
    parameter int NTAP = 8,
    parameter int DW   = 16,
    localparam int PHW = $clog2(NPH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PHW-1:0]       addr,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] taps [NTAP]
);
    // Row k holds sample n-64(k+1) of every branch slot
    logic signed [DW-1:0] mem [NTAP-1][NPH];

    always_comb begin
        taps[0] = din;
        for (int k = 1; k < NTAP; k++) taps[k] = mem[k-1][addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAP-1; k++)
                for (int j = 0; j < NPH; j++) mem[k][j] <= '0;
        end else if (wr_en) begin
            mem[0][addr] <= din;
            for (int k = 1; k < NTAP-1; k++) mem[k][addr] <= mem[k-1][addr];
        end
    end

    // R7
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[0][$past(addr)] == $past(din));
    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> mem[0][$past(addr)] == $past(mem[0][addr]));
endmodule

// File: rtl/pp_coef_rom.sv
module pp_coef_rom #(
    parameter int NPH  = 64,
    parameter int NTAP = 8,
    parameter int CW   = 16,
    localparam int PHW = $clog2(NPH)
) (
    input  logic                 clk,
    input  logic [PHW-1:0]       addr,
    output logic signed [CW-1:0] coef [NTAP]
);
    import pp_chan_pkg::*;

    logic signed [CW-1:0] rom [NTAP][NPH];

    always_comb begin
        for (int k = 0; k < NTAP; k++)
            for (int j = 0; j < NPH; j++)
                rom[k][j] = CW'(coef_at(k * NPH + j));
    end

    // One row per branch, all taps read in one registered access
    always_ff @(posedge clk) begin
        for (int k = 0; k < NTAP; k++) coef[k] <= rom[k][addr];
    end
endmodule

// File: rtl/pp_adder_tree.sv
module pp_adder_tree #(
    parameter int NTAP = 8,
    parameter int OW   = 35,
    localparam int LV  = $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic signed [OW-1:0] terms [NTAP],
    output logic signed [OW-1:0] total
);
    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int N = NTAP >> (l + 1);
        logic signed [OW-1:0] s [N];
        if (l == 0) begin : g_first
            always_ff @(posedge clk)
                for (int j = 0; j < N; j++) s[j] <= terms[2*j] + terms[2*j+1];
        end else begin : g_next
            always_ff @(posedge clk)
                for (int j = 0; j < N; j++)
                    s[j] <= g_lvl[l-1].s[2*j] + g_lvl[l-1].s[2*j+1];
        end
    end

    assign total = g_lvl[LV-1].s[0];
endmodule

// File: rtl/pp_channelizer.sv
module pp_channelizer #(
    parameter int NPH  = 64,
    parameter int NTAP = 8,
    parameter int DW   = 16,
    parameter int CW   = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [DW-1:0]                            in_data,
    output logic                                     out_valid,
    output logic [DW+CW+$clog2(NTAP)-1:0]            out_data,
    output logic [$clog2(NPH)-1:0]                   out_phase,
    output logic                                     out_first
);
    localparam int PHW = $clog2(NPH);
    localparam int LV  = $clog2(NTAP);
    localparam int PW  = DW + CW;
    localparam int OW  = PW + LV;
    localparam int LAT = 2 + LV;

    typedef enum logic {ADVANCE, HOLD} step_e;

    step_e                 step;
    logic [PHW-1:0]        ph;
    logic signed [DW-1:0]  taps   [NTAP];
    logic signed [DW-1:0]  tap_q  [NTAP];
    logic signed [CW-1:0]  coef_q [NTAP];
    logic signed [PW-1:0]  mul    [NTAP];
    logic signed [OW-1:0]  prod   [NTAP];
    logic signed [OW-1:0]  total;
    logic [LAT-1:0]        vq, fq;
    logic [PHW-1:0]        pq [LAT];

    // Branch counter: ADVANCE on accepted sample, HOLD otherwise
    always_comb step = in_valid ? ADVANCE : HOLD;

    always_ff @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else begin
            unique case (step)
                ADVANCE: ph <= (ph == PHW'(NPH-1)) ? '0 : ph + 1'b1;
                HOLD:    ph <= ph;
            endcase
        end
    end

    pp_delay_bank #(.NPH(NPH), .NTAP(NTAP), .DW(DW)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .addr(ph),
        .din(DW'(signed'(in_data))), .taps(taps));

    pp_coef_rom #(.NPH(NPH), .NTAP(NTAP), .CW(CW)) i_rom (
        .clk(clk), .addr(ph), .coef(coef_q));

    always_comb
        for (int k = 0; k < NTAP; k++) mul[k] = PW'(tap_q[k]) * PW'(coef_q[k]);

    always_ff @(posedge clk) begin
        for (int k = 0; k < NTAP; k++) begin
            tap_q[k] <= taps[k];
            prod[k]  <= {{(OW-PW){mul[k][PW-1]}}, mul[k]};
        end
    end

    pp_adder_tree #(.NTAP(NTAP), .OW(OW)) i_tree (
        .clk(clk), .terms(prod), .total(total));

    // Qualifier, branch index and frame flag travel alongside the datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vq <= '0;
            fq <= '0;
            for (int i = 0; i < LAT; i++) pq[i] <= '0;
        end else begin
            vq <= {vq[LAT-2:0], in_valid};
            fq <= {fq[LAT-2:0], in_valid && (ph == '0)};
            pq[0] <= ph;
            for (int i = 1; i < LAT; i++) pq[i] <= pq[i-1];
        end
    end

    assign out_valid = vq[LAT-1];
    assign out_first = fq[LAT-1];
    assign out_phase = pq[LAT-1];
    assign out_data  = total;

    // Checker state: last branch index seen on a valid output
    logic [PHW-1:0] last_ph;
    logic           seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= 1'b0;
            last_ph <= '0;
        end else if (out_valid) begin
            seen    <= 1'b1;
            last_ph <= out_phase;
        end
    end

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ph == PHW'(NPH-1)) |=> ph == '0);
    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ph));
    // R3
    frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_first == (out_phase == '0)));
    // R8
    phase_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |->
            out_phase == ((last_ph == PHW'(NPH-1)) ? '0 : last_ph + 1'b1));
    // R1
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_first);
endmodule

// File: tb/test_pp_channelizer.sv
module test_pp_channelizer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic        out_valid;
    logic [34:0] out_data;
    logic [5:0]  out_phase;
    logic        out_first;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    pp_channelizer i_pp_channelizer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .out_phase(out_phase), .out_first(out_first));

    // Reference model state
    int     hist[$];
    bit     ev [5];
    longint ed [5];
    int     ep [5];

    function automatic longint h(int i);
        return longint'(((i * 37 + 11) % 251) - 125);
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare outputs against the model, then present the next input
    task automatic step(bit v, int d);
        @(negedge clk);
        chk(out_valid == ev[4], "R6 R7 R8 valid", longint'(out_valid), longint'(ev[4]));
        if (ev[4] && out_valid) begin
            chk(longint'($signed(out_data)) == ed[4], "R4 R5 R9 data",
                longint'($signed(out_data)), ed[4]);
            chk(int'(out_phase) == ep[4], "R2 phase", longint'(out_phase), longint'(ep[4]));
            chk(out_first == (ep[4] == 0), "R3 first", longint'(out_first),
                longint'(ep[4] == 0));
        end
        for (int i = 4; i > 0; i--) begin
            ev[i] = ev[i-1]; ed[i] = ed[i-1]; ep[i] = ep[i-1];
        end
        ev[0] = v; ed[0] = 0; ep[0] = 0;
        if (v) begin
            int n = hist.size();
            longint s = 0;
            hist.push_back(d);
            for (int k = 0; k < 8; k++) begin
                int idx = n - 64 * k;
                if (idx >= 0) s += h(64 * k + n % 64) * longint'(hist[idx]);
            end
            ed[0] = s;
            ep[0] = n % 64;
        end
        in_valid = v;
        in_data  = v ? 16'(d) : 16'hA5A5;   // idle cycles carry junk (R7)
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        for (int i = 0; i < 5; i++) begin ev[i] = 0; ed[i] = 0; ep[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
        chk(out_first == 1'b0, "R1 reset first", longint'(out_first), 0);
        rst_n = 1'b1;
        // R1 R8: continuous ramp over zero history
        for (int i = 0; i < 600; i++) step(1, (i * 53) % 2001 - 1000);
        // R7: gapped random stream
        for (int i = 0; i < 700; i++)
            step(($urandom % 3) != 0, int'($urandom % 65536) - 32768);
        // R9: full-scale blocks
        for (int i = 0; i < 520; i++) step(1, -32768);
        for (int i = 0; i < 520; i++) step(1, (i % 2) ? 32767 : -32768);
        for (int i = 0; i < 8; i++) step(0, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule